// File: doc/BRIEF.md
# Rotating Ring Membership Network for Boundary-Metric Buses

This block sets which decoder processors of a component decoder take part in the boundary state metric exchange, and rewires the ring buses between them. A configuration write gives a member count and a starting node. The members are the count consecutive nodes, taken cyclically, beginning at the starting node. The block stores a one-bit-per-node selection vector. This vector steers a multiplexer in front of every node, so the members form a closed loop and non-members drop out of the path.

Every component decoder has two metric buses. The forward bus delivers each member's data to the following member, and the last member feeds the first. The backward bus runs the other way, and the first member feeds the last. Both component decoders share one selection vector and one configuration. The data paths are combinational from the stored configuration. A configuration that cannot be realised is refused: the stored one stays in force and an error flag is raised.

Top module: `ring_bypass_net`

## Requirements
- R1: After reset all NODES nodes are members, the first member is node 0, the selection vector is all ones and cfg_err_o is 0.
- R2: When cfg_valid_i is high with 1 <= cfg_count_i <= NODES and cfg_shift_i < NODES, the selection vector at the next clock edge has bit k set exactly for the nodes k = (cfg_shift_i + j) mod NODES, j = 0 .. cfg_count_i-1. Bit k of sel_vec_o belongs to node k.
- R3: When cfg_valid_i is high with cfg_count_i = 0, cfg_count_i > NODES or cfg_shift_i >= NODES, the selection vector and all routing stay unchanged and cfg_err_o is 1 after the next edge.
- R4: cfg_err_o stays 1 until an accepted configuration, which clears it at the next edge.
- R5: On the forward bus each member receives, on its rx lane, the tx lane of the preceding member in cyclic order. The first member (the shift node) receives from the last member.
- R6: On the backward bus each member receives the tx lane of the following member. The last member receives from the first member.
- R7: A non-member node receives all zeros on both buses.
- R8: With a single member, that node receives its own tx data on both buses.
- R9: Decoder 1 is routed with the same vector and order as decoder 0, each from its own tx data.
- R10: While cfg_valid_i is low, the configuration inputs have no effect on the vector, the error flag or the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_count_i | input | CNT_W | Requested number of members |
| cfg_shift_i | input | CNT_W | Index of the first member |
| sel_vec_o | output | NODES | Stored selection vector, bit k = node k |
| cfg_err_o | output | 1 | Last configuration write was refused |
| dec0_fwd_tx_i | input | NODES*WIDTH | Decoder 0 forward-bus data sent by each node (lane k = node k) |
| dec0_bwd_tx_i | input | NODES*WIDTH | Decoder 0 backward-bus data sent by each node |
| dec1_fwd_tx_i | input | NODES*WIDTH | Decoder 1 forward-bus data sent by each node |
| dec1_bwd_tx_i | input | NODES*WIDTH | Decoder 1 backward-bus data sent by each node |
| dec0_fwd_rx_o | output | NODES*WIDTH | Decoder 0 forward-bus data received by each node |
| dec0_bwd_rx_o | output | NODES*WIDTH | Decoder 0 backward-bus data received by each node |
| dec1_fwd_rx_o | output | NODES*WIDTH | Decoder 1 forward-bus data received by each node |
| dec1_bwd_rx_o | output | NODES*WIDTH | Decoder 1 backward-bus data received by each node |

## Verification
Two things can change at the same edge: the stored configuration, whether accepted or refused, and the tx data on all four buses. The bench changes the tx data together with every configuration write. Just after that edge it checks each rx lane against a ring order that it rebuilds from its own model. The rx lanes must carry the new data routed by the new membership, or by the old membership when the write was refused. Refused writes include zero, oversized and out-of-range-shift requests, mixed with random accepted ones.

// File: rtl/rbn_pkg.sv
package rbn_pkg;

  // true when node idx lies inside the cyclic window [first, first+cnt)
  function automatic logic in_window(int idx, int first, int cnt, int n);
    int d;
    d = (idx - first + n) % n;
    return (d < cnt);
  endfunction

  function automatic logic cfg_ok(int cnt, int first, int n);
    return (cnt >= 1) && (cnt <= n) && (first < n);
  endfunction

  // member that feeds idx on the forward bus
  function automatic int prev_of(int idx, int first, int cnt, int n);
    if (idx == first) return (first + cnt - 1) % n;
    return (idx + n - 1) % n;
  endfunction

  // member that feeds idx on the backward bus
  function automatic int next_of(int idx, int first, int cnt, int n);
    if (idx == (first + cnt - 1) % n) return first;
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/rbn_cfg.sv
module rbn_cfg #(
  parameter int NODES = 4,
  parameter int CNT_W = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic [CNT_W-1:0] cfg_shift_i,
  output logic [NODES-1:0] sel_vec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] shift_o,
  output logic             err_o
);
  import rbn_pkg::*;

  logic             cfg_take;
  logic             cfg_bad;
  logic [NODES-1:0] vec_next;
  logic [NODES-1:0] sel_vec_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shift_q;
  logic             err_q;

  assign cfg_take = cfg_valid_i &&  cfg_ok(int'(cfg_count_i), int'(cfg_shift_i), NODES);
  assign cfg_bad  = cfg_valid_i && !cfg_ok(int'(cfg_count_i), int'(cfg_shift_i), NODES);

  for (genvar k = 0; k < NODES; k++) begin : g_vec
    assign vec_next[k] = in_window(k, int'(cfg_shift_i), int'(cfg_count_i), NODES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_vec_q <= '1;
      cnt_q     <= CNT_W'(NODES);
      shift_q   <= '0;
      err_q     <= 1'b0;
    end else if (cfg_take) begin
      sel_vec_q <= vec_next;
      cnt_q     <= cfg_count_i;
      shift_q   <= cfg_shift_i;
      err_q     <= 1'b0;
    end else if (cfg_bad) begin
      err_q     <= 1'b1;
    end
  end

  assign sel_vec_o = sel_vec_q;
  assign cnt_o     = cnt_q;
  assign shift_o   = shift_q;
  assign err_o     = err_q;

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> $stable(sel_vec_q) && $stable(cnt_q) && $stable(shift_q));
  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> err_q);
  // R4
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> !err_q);
  // R2
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_vec_q) == int'(cnt_q));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid_i |=> $stable(sel_vec_q) && $stable(err_q));
  // R2
  first_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vec_q[shift_q[$clog2(NODES)-1:0]]);

endmodule

// File: rtl/rbn_route.sv
module rbn_route #(
  parameter int NODES = 4,
  parameter int WIDTH = 44,
  parameter int CNT_W = $clog2(NODES + 1)
) (
  input  logic [NODES-1:0]       sel_vec_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [CNT_W-1:0]       shift_i,
  input  logic [NODES*WIDTH-1:0] fwd_tx_i,
  input  logic [NODES*WIDTH-1:0] bwd_tx_i,
  output logic [NODES*WIDTH-1:0] fwd_rx_o,
  output logic [NODES*WIDTH-1:0] bwd_rx_o
);
  import rbn_pkg::*;
  localparam int IW = $clog2(NODES);

  logic [WIDTH-1:0] fwd_tx_a [NODES];
  logic [WIDTH-1:0] bwd_tx_a [NODES];

  for (genvar k = 0; k < NODES; k++) begin : g_node
    logic [IW-1:0] src_prev;
    logic [IW-1:0] src_next;

    assign fwd_tx_a[k] = fwd_tx_i[k*WIDTH +: WIDTH];
    assign bwd_tx_a[k] = bwd_tx_i[k*WIDTH +: WIDTH];
    assign src_prev = IW'(prev_of(k, int'(shift_i), int'(cnt_i), NODES));
    assign src_next = IW'(next_of(k, int'(shift_i), int'(cnt_i), NODES));

    // bypass: a node outside the ring sees an idle (zero) bus
    assign fwd_rx_o[k*WIDTH +: WIDTH] = sel_vec_i[k] ? fwd_tx_a[src_prev] : '0;
    assign bwd_rx_o[k*WIDTH +: WIDTH] = sel_vec_i[k] ? bwd_tx_a[src_next] : '0;
  end

endmodule

// File: rtl/ring_bypass_net.sv
module ring_bypass_net #(
  parameter int NODES = 4,
  parameter int WIDTH = 44,
  parameter int CNT_W = $clog2(NODES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_valid_i,
  input  logic [CNT_W-1:0]       cfg_count_i,
  input  logic [CNT_W-1:0]       cfg_shift_i,
  output logic [NODES-1:0]       sel_vec_o,
  output logic                   cfg_err_o,
  input  logic [NODES*WIDTH-1:0] dec0_fwd_tx_i,
  input  logic [NODES*WIDTH-1:0] dec0_bwd_tx_i,
  input  logic [NODES*WIDTH-1:0] dec1_fwd_tx_i,
  input  logic [NODES*WIDTH-1:0] dec1_bwd_tx_i,
  output logic [NODES*WIDTH-1:0] dec0_fwd_rx_o,
  output logic [NODES*WIDTH-1:0] dec0_bwd_rx_o,
  output logic [NODES*WIDTH-1:0] dec1_fwd_rx_o,
  output logic [NODES*WIDTH-1:0] dec1_bwd_rx_o
);
  localparam int DECS = 2;

  logic [NODES-1:0]       sel_vec;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       shift_q;
  logic [NODES*WIDTH-1:0] ftx [DECS];
  logic [NODES*WIDTH-1:0] btx [DECS];
  logic [NODES*WIDTH-1:0] frx [DECS];
  logic [NODES*WIDTH-1:0] brx [DECS];

  rbn_cfg #(.NODES(NODES), .CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid_i(cfg_valid_i),
    .cfg_count_i(cfg_count_i), .cfg_shift_i(cfg_shift_i),
    .sel_vec_o(sel_vec), .cnt_o(cnt_q), .shift_o(shift_q), .err_o(cfg_err_o)
  );

  assign ftx[0] = dec0_fwd_tx_i;
  assign btx[0] = dec0_bwd_tx_i;
  assign ftx[1] = dec1_fwd_tx_i;
  assign btx[1] = dec1_bwd_tx_i;

  for (genvar d = 0; d < DECS; d++) begin : g_dec
    rbn_route #(.NODES(NODES), .WIDTH(WIDTH), .CNT_W(CNT_W)) route_i (
      .sel_vec_i(sel_vec), .cnt_i(cnt_q), .shift_i(shift_q),
      .fwd_tx_i(ftx[d]), .bwd_tx_i(btx[d]),
      .fwd_rx_o(frx[d]), .bwd_rx_o(brx[d])
    );
  end

  assign dec0_fwd_rx_o = frx[0];
  assign dec0_bwd_rx_o = brx[0];
  assign dec1_fwd_rx_o = frx[1];
  assign dec1_bwd_rx_o = brx[1];
  assign sel_vec_o     = sel_vec;

endmodule

// File: tb/ring_bypass_net_tb_top.sv
`timescale 1ns/1ps
module ring_bypass_net_tb_top;
  localparam int N  = 4;
  localparam int W  = 44;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid_i = 1'b0;
  logic [CW-1:0] cfg_count_i = '0;
  logic [CW-1:0] cfg_shift_i = '0;
  logic [N-1:0]  sel_vec_o;
  logic          cfg_err_o;
  logic [N*W-1:0] tx [4];
  logic [N*W-1:0] rx [4];

  int checks = 0;
  int errors = 0;
  int m_cnt = N;
  int m_sh = 0;
  bit m_err = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ring_bypass_net #(.NODES(N), .WIDTH(W), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid_i(cfg_valid_i),
    .cfg_count_i(cfg_count_i), .cfg_shift_i(cfg_shift_i),
    .sel_vec_o(sel_vec_o), .cfg_err_o(cfg_err_o),
    .dec0_fwd_tx_i(tx[0]), .dec0_bwd_tx_i(tx[1]),
    .dec1_fwd_tx_i(tx[2]), .dec1_bwd_tx_i(tx[3]),
    .dec0_fwd_rx_o(rx[0]), .dec0_bwd_rx_o(rx[1]),
    .dec1_fwd_rx_o(rx[2]), .dec1_bwd_rx_o(rx[3])
  );

  function automatic logic [W-1:0] lane(logic [N*W-1:0] v, int k);
    return v[k*W +: W];
  endfunction

  function automatic int ring_pos(int k);
    return (m_sh + k) % N;
  endfunction

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v = '0;
    for (int k = 0; k < m_cnt; k++) v[ring_pos(k)] = 1'b1;
    return v;
  endfunction

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    logic [W-1:0] seen [N];
    checks++;
    if (sel_vec_o !== model_vec() || cfg_err_o !== m_err) begin
      errors++;
      $display("FAIL %s vec/err actual=%b/%b expected=%b/%b",
               tag, sel_vec_o, cfg_err_o, model_vec(), m_err);
    end
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < N; k++) seen[k] = '0;
      for (int k = 0; k < m_cnt; k++) begin
        if (b % 2 == 0) seen[ring_pos(k)] = lane(tx[b], ring_pos((k + m_cnt - 1) % m_cnt));
        else            seen[ring_pos(k)] = lane(tx[b], ring_pos((k + 1) % m_cnt));
      end
      for (int k = 0; k < N; k++) begin
        if (!model_vec()[k])     cmp({tag, " R7 bypass"}, lane(rx[b], k), seen[k]);
        else if (m_cnt == 1)     cmp({tag, " R8 single"}, lane(rx[b], k), seen[k]);
        else if (b >= 2)         cmp({tag, " R9 dec1"}, lane(rx[b], k), seen[k]);
        else if (b == 0)         cmp({tag, " R5 fwd"}, lane(rx[b], k), seen[k]);
        else                     cmp({tag, " R6 bwd"}, lane(rx[b], k), seen[k]);
      end
    end
  endtask

  task automatic new_data();
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < N; k++)
        tx[b][k*W +: W] = {$urandom, $urandom};
  endtask

  task automatic apply(bit v, int cnt, int sh, string tag);
    @(negedge clk);
    cfg_valid_i = v;
    cfg_count_i = CW'(cnt);
    cfg_shift_i = CW'(sh);
    new_data();
    @(posedge clk);
    #1;
    if (v) begin
      if (cnt >= 1 && cnt <= N && sh < N) begin
        m_cnt = cnt; m_sh = sh; m_err = 1'b0;
      end else m_err = 1'b1;
    end
    check_state(tag);
    cfg_valid_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0013));
    new_data();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_state("R1 reset");
    apply(1, 2, 1, "R2 two from 1");
    apply(1, 3, 2, "R2 three from 2 wrap");
    apply(0, 1, 3, "R10 idle ignored");
    apply(1, 0, 0, "R3 zero count");
    apply(0, 2, 2, "R4 err held");
    apply(1, 5, 1, "R3 count too big");
    apply(1, 2, 4, "R3 shift out of range");
    apply(1, 1, 3, "R4 cleared single");
    apply(1, 4, 3, "R2 full ring rotated");
    apply(1, 3, 0, "R2 three from 0");
    for (int it = 0; it < 400; it++) begin
      apply(($urandom % 4) != 0, $urandom % 6, $urandom % 5, "R2 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule